// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file that shows software 32 registers at a time. The physical storage is larger than what software sees. Eight global registers are always visible. The other 24 visible registers come from a sliding window into a bank of per-window storage, selected by a current-window pointer. Neighbouring windows share eight registers. The registers a caller writes as its outgoing group are the same storage the callee then reads as its incoming group, so arguments and results cross a call boundary without any copy.

The window moves only on explicit save and restore requests. A window controller keeps the pointer and a count of occupied windows. It holds that count as three named occupancy states:

- `OCC_ONE`: only the base window is in use.
- `OCC_MID`: some windows are in use, with room for more.
- `OCC_FULL`: every usable window is occupied.

The controller takes one of five transitions on each cycle:

- `SAVE_GROW`: a save with room left.
- `SAVE_TRAP`: a save from `OCC_FULL`.
- `RESTORE_SHRINK`: a restore with more than one window occupied.
- `RESTORE_TRAP`: a restore from `OCC_ONE`.
- `IDLE_HOLD`: no request, or save and restore requested together.

A trapping request leaves the pointer and the count unchanged and raises a one-cycle trap pulse. Spilling and filling windows to memory is left to trap software outside this block. There are two combinational read ports and one synchronous write port.

Top module: `rf_windowed`

## Requirements
- R1: Visible indices 0 to 7 address eight global registers that hold the same values in every window.
- R2: Visible index 0 always reads as zero, and writes to it are discarded.
- R3: Visible indices 8 to 15 are the outgoing group and 16 to 23 the local group; both are private to the current window.
- R4: Visible indices 24 to 31 are the incoming group. In window w it is the same storage as the outgoing group of window w-1 (modulo NWIN), so a value written through either name is read through the other.
- R5: When no trap applies, a save moves `cur_win` to cur_win+1 and a restore moves it to cur_win-1, both modulo NWIN, visible after the clock edge.
- R6: A save while NWIN-1 windows are occupied pulses `ovf_trap` high for the one cycle after the edge. The pointer and the occupancy count stay unchanged.
- R7: A restore while one window is occupied pulses `unf_trap` high for the one cycle after the edge. The pointer and the occupancy count stay unchanged.
- R8: Save and restore requested in the same cycle are ignored: no pointer change and no trap.
- R9: A write in the same cycle as a save or restore is placed using the window mapping from before the pointer moves.
- R10: After reset, `cur_win` is 0, one window is occupied, both traps are low, and every register reads zero.
- R11: A trap output is low after any cycle that carried no trapping request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Visible register index for read port A |
| rd_a_data | output | W | Read port A data (combinational) |
| rd_b_idx | input | 5 | Visible register index for read port B |
| rd_b_data | output | W | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Visible register index to write |
| wr_data | input | W | Write data |
| save_req | input | 1 | Advance to a new window |
| restore_req | input | 1 | Return to the previous window |
| cur_win | output | log2(NWIN) | Current-window pointer |
| ovf_trap | output | 1 | One-cycle overflow trap pulse |
| unf_trap | output | 1 | One-cycle underflow trap pulse |

## Verification
The hardest condition to reach from the ports is a full file. The overflow path, and the fact that a trapped save keeps the count, show only after NWIN-2 successful saves in a row. A concurrent write must land in the outgoing group of the window being left. The bench walks the window all the way up to the overflow trap and all the way back down to the underflow trap. At every window it writes distinct values into every visible register and sweeps all 32 indices on both read ports against a per-window model. Writes ride on the save and restore cycles themselves, so the old-mapping rule is checked at each step.

// File: rtl/rfw_pkg.sv
package rfw_pkg;
    // Visible index groups, decoded from bits [4:3] of the register index
    localparam logic [1:0] GRP_GLOBAL = 2'd0;
    localparam logic [1:0] GRP_OUT    = 2'd1;
    localparam logic [1:0] GRP_LOCAL  = 2'd2;
    localparam logic [1:0] GRP_IN     = 2'd3;

    localparam int GRP_SIZE  = 8;
    localparam int WIN_SLICE = 2 * GRP_SIZE;   // outs + locals owned per window

    typedef enum logic [1:0] {
        OCC_ONE,
        OCC_MID,
        OCC_FULL
    } occ_state_t;

    typedef enum logic [2:0] {
        SAVE_GROW,
        SAVE_TRAP,
        RESTORE_SHRINK,
        RESTORE_TRAP,
        IDLE_HOLD
    } win_move_t;
endpackage

// File: rtl/rfw_ctrl.sv
module rfw_ctrl
    import rfw_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW = $clog2(NWIN),
    localparam int OCCW = $clog2(NWIN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    output logic [CWPW-1:0] cwp,
    output logic            ovf_trap,
    output logic            unf_trap
);
    localparam logic [OCCW-1:0] OCC_MAX = OCCW'(NWIN - 1);
    localparam logic [OCCW-1:0] OCC_MIN = OCCW'(1);

    occ_state_t      state_q, state_d;
    win_move_t       move;
    logic [OCCW-1:0] occ_q, occ_d;
    logic [CWPW-1:0] cwp_d;
    logic            ovf_d, unf_d;
    logic            do_save, do_restore;

    assign do_save    = save_req && !restore_req;
    assign do_restore = restore_req && !save_req;

    // pick the transition taken this cycle
    always_comb begin
        move = IDLE_HOLD;
        unique case (state_q)
            OCC_ONE: begin
                if (do_save)         move = SAVE_GROW;
                else if (do_restore) move = RESTORE_TRAP;
            end
            OCC_MID: begin
                if (do_save)         move = SAVE_GROW;
                else if (do_restore) move = RESTORE_SHRINK;
            end
            OCC_FULL: begin
                if (do_save)         move = SAVE_TRAP;
                else if (do_restore) move = RESTORE_SHRINK;
            end
            default: move = IDLE_HOLD;
        endcase
    end

    // next-state values
    always_comb begin
        state_d = state_q;
        occ_d   = occ_q;
        cwp_d   = cwp;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        unique case (move)
            SAVE_GROW: begin
                occ_d   = occ_q + OCCW'(1);
                cwp_d   = (cwp == CWPW'(NWIN - 1)) ? '0 : cwp + CWPW'(1);
                state_d = (occ_q + OCCW'(1) == OCC_MAX) ? OCC_FULL : OCC_MID;
            end
            RESTORE_SHRINK: begin
                occ_d   = occ_q - OCCW'(1);
                cwp_d   = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - CWPW'(1);
                state_d = (occ_q - OCCW'(1) == OCC_MIN) ? OCC_ONE : OCC_MID;
            end
            SAVE_TRAP:    ovf_d = 1'b1;
            RESTORE_TRAP: unf_d = 1'b1;
            IDLE_HOLD:    ;
            default:      ;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_ONE;
            occ_q   <= OCC_MIN;
            cwp     <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            cwp     <= cwp_d;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
        end else begin
            ovf_trap <= ovf_d;
            unf_trap <= unf_d;
        end
    end
endmodule

// File: rtl/rfw_map.sv
module rfw_map
    import rfw_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW  = $clog2(NWIN),
    localparam int NPHYS = GRP_SIZE + WIN_SLICE * NWIN,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic [4:0]      vis_idx,
    input  logic [CWPW-1:0] cwp,
    output logic [PW-1:0]   phys_idx
);
    logic [CWPW-1:0] caller;
    int              off;

    always_comb begin
        caller = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - CWPW'(1);
        off    = int'(vis_idx[2:0]);
        unique case (vis_idx[4:3])
            GRP_GLOBAL: phys_idx = PW'(off);
            GRP_OUT:    phys_idx = PW'(GRP_SIZE + WIN_SLICE * int'(cwp) + off);
            GRP_LOCAL:  phys_idx = PW'(GRP_SIZE + WIN_SLICE * int'(cwp) + GRP_SIZE + off);
            GRP_IN:     phys_idx = PW'(GRP_SIZE + WIN_SLICE * int'(caller) + off);
            default:    phys_idx = '0;
        endcase
    end
endmodule

// File: rtl/rfw_store.sv
module rfw_store #(
    parameter int W     = 32,
    parameter int NPHYS = 136,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [PW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [PW-1:0] w_idx,
    input  logic [W-1:0]  w_data
);
    logic [W-1:0] regs [NPHYS];

    // entry 0 is the hard-wired zero global
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
        end else if (we && w_idx != '0) begin
            regs[w_idx] <= w_data;
        end
    end

    assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
endmodule

// File: rtl/rf_windowed.sv
module rf_windowed
    import rfw_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int W    = 32,
    localparam int CWPW  = $clog2(NWIN),
    localparam int NPHYS = GRP_SIZE + WIN_SLICE * NWIN,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [W-1:0]    rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [W-1:0]    rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    output logic [CWPW-1:0] cur_win,
    output logic            ovf_trap,
    output logic            unf_trap
);
    localparam int NPORT = 3;   // read A, read B, write

    logic [4:0]    vis   [NPORT];
    logic [PW-1:0] phys  [NPORT];

    assign vis[0] = rd_a_idx;
    assign vis[1] = rd_b_idx;
    assign vis[2] = wr_idx;

    rfw_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cwp         (cur_win),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    // every port maps through the pointer held before this edge
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rfw_map #(.NWIN(NWIN)) u_map (
            .vis_idx  (vis[p]),
            .cwp      (cur_win),
            .phys_idx (phys[p])
        );
    end

    rfw_store #(.W(W), .NPHYS(NPHYS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (phys[0]),
        .ra_data (rd_a_data),
        .rb_idx  (phys[1]),
        .rb_data (rd_b_data),
        .we      (wr_en),
        .w_idx   (phys[2]),
        .w_data  (wr_data)
    );
endmodule

// File: rtl/rfw_chk.sv
module rfw_chk #(
    parameter int NWIN = 8,
    parameter int W    = 32,
    localparam int CWPW = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      rd_a_idx,
    input logic [W-1:0]    rd_a_data,
    input logic [4:0]      rd_b_idx,
    input logic [W-1:0]    rd_b_data,
    input logic            save_req,
    input logic            restore_req,
    input logic [CWPW-1:0] cur_win,
    input logic            ovf_trap,
    input logic            unf_trap
);
    // R2
    zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == 5'd0 |-> rd_a_data == '0);
    // R2
    zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_idx == 5'd0 |-> rd_b_data == '0);
    // R5
    save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req) |=>
            (ovf_trap ? $stable(cur_win)
                      : cur_win == (($past(cur_win) == CWPW'(NWIN - 1)) ? '0 : $past(cur_win) + CWPW'(1))));
    // R5
    restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req) |=>
            (unf_trap ? $stable(cur_win)
                      : cur_win == (($past(cur_win) == '0) ? CWPW'(NWIN - 1) : $past(cur_win) - CWPW'(1))));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req == restore_req) |=> ($stable(cur_win) && !ovf_trap && !unf_trap));
    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> ($past(save_req) && !$past(restore_req)));
    // R7
    unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> ($past(restore_req) && !$past(save_req)));
    // R11
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));
endmodule

bind rf_windowed rfw_chk #(.NWIN(NWIN), .W(W)) u_rfw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .cur_win     (cur_win),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/tb_rf_windowed.sv
`timescale 1ns/1ps
module tb_rf_windowed;
    localparam int NWIN = 8;
    localparam int W    = 32;
    localparam int CWPW = $clog2(NWIN);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [W-1:0]    rd_a_data, rd_b_data, wr_data = '0;
    logic            wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [CWPW-1:0] cur_win;
    logic            ovf_trap, unf_trap;

    int errors = 0;
    int checks = 0;

    // model from the requirements
    logic [W-1:0] m_gl  [8];
    logic [W-1:0] m_out [NWIN][8];
    logic [W-1:0] m_loc [NWIN][8];
    int m_win = 0;
    int m_occ = 1;

    always #2.5 clk = ~clk;

    rf_windowed #(.NWIN(NWIN), .W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .cur_win(cur_win), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] m_read(input int idx);
        int o = idx % 8;
        if (idx == 0) return '0;
        if (idx < 8)  return m_gl[o];
        if (idx < 16) return m_out[m_win][o];
        if (idx < 24) return m_loc[m_win][o];
        return m_out[(m_win + NWIN - 1) % NWIN][o];
    endfunction

    function automatic void m_write(input int idx, input logic [W-1:0] d);
        int o = idx % 8;
        if (idx == 0) return;
        if (idx < 8)       m_gl[o] = d;
        else if (idx < 16) m_out[m_win][o] = d;
        else if (idx < 24) m_loc[m_win][o] = d;
        else               m_out[(m_win + NWIN - 1) % NWIN][o] = d;
    endfunction

    function automatic string tag_of(input int idx);
        if (idx == 0)  return "R2";
        if (idx < 8)   return "R1";
        if (idx < 24)  return "R3";
        return "R4";
    endfunction

    // sweep both read ports over all visible indices (between edges)
    task automatic check_all();
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            #0.2;
            check(tag_of(i), rd_a_data, m_read(i));
            check(tag_of(31 - i), rd_b_data, m_read(31 - i));
        end
    endtask

    // one clock with the given request; write data lands with the old window (R9)
    task automatic step(input logic sv, input logic rs, input logic we,
                        input int widx, input logic [W-1:0] wd);
        logic exp_ovf, exp_unf;
        @(negedge clk);
        save_req = sv; restore_req = rs; wr_en = we;
        wr_idx = 5'(widx); wr_data = wd;
        exp_ovf = sv && !rs && (m_occ == NWIN - 1);
        exp_unf = rs && !sv && (m_occ == 1);
        if (we) m_write(widx, wd);
        if (sv && !rs && !exp_ovf) begin m_win = (m_win + 1) % NWIN; m_occ++; end
        if (rs && !sv && !exp_unf) begin m_win = (m_win + NWIN - 1) % NWIN; m_occ--; end
        @(posedge clk);
        #1;
        save_req = 1'b0; restore_req = 1'b0; wr_en = 1'b0;
        check((sv && rs) ? "R8" : "R5", W'(cur_win), W'(m_win));
        check(exp_ovf ? "R6" : "R11", W'(ovf_trap), W'(exp_ovf));
        check(exp_unf ? "R7" : "R11", W'(unf_trap), W'(exp_unf));
    endtask

    // fill window-visible registers with values tagged by window and index
    task automatic fill_window(input int salt);
        for (int i = 1; i < 32; i++) begin
            if (i < 8 && salt != 0) continue;   // globals written once
            step(1'b0, 1'b0, 1'b1, i, {8'(salt), 8'(m_win), 8'(i), 8'hA5});
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_gl[i] = '0;
        for (int w = 0; w < NWIN; w++)
            for (int i = 0; i < 8; i++) begin m_out[w][i] = '0; m_loc[w][i] = '0; end

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state
        check("R10", W'(cur_win), '0);
        check("R10", W'(ovf_trap), '0);
        check("R10", W'(unf_trap), '0);
        check_all();

        // R2: write to index 0 discarded
        step(1'b0, 1'b0, 1'b1, 0, 32'hDEAD_BEEF);
        rd_a_idx = 5'd0; #0.2;
        check("R2", rd_a_data, '0);

        // base window contents including globals
        fill_window(0);
        check_all();

        // R7: restore from a single occupied window
        step(1'b0, 1'b1, 1'b0, 0, '0);
        check_all();

        // walk up, a write to an outgoing register rides on each save (R9, R4)
        for (int s = 0; s < NWIN - 2; s++) begin
            step(1'b1, 1'b0, 1'b1, 8 + (s % 8), {8'hC0, 8'(s), 16'h5A5A});
            check_all();
            fill_window(s + 1);
            check_all();
        end

        // R6: overflow with NWIN-1 occupied, write still applied
        step(1'b1, 1'b0, 1'b1, 17, 32'h0F0F_1234);
        check_all();
        step(1'b1, 1'b0, 1'b0, 0, '0);

        // R8: simultaneous save and restore ignored
        step(1'b1, 1'b1, 1'b0, 0, '0);
        check_all();

        // walk down; write to an incoming register rides on each restore (R9)
        for (int s = 0; s < NWIN - 2; s++) begin
            step(1'b0, 1'b1, 1'b1, 24 + (s % 8), {8'hD0, 8'(s), 16'h3C3C});
            check_all();
        end

        // R7: underflow at the base again; R11: idle cycle leaves traps low
        step(1'b0, 1'b1, 1'b0, 0, '0);
        step(1'b0, 1'b0, 1'b0, 0, '0);
        check_all();

        // R5: one more save after a full round still steps normally
        step(1'b1, 1'b0, 1'b0, 0, '0);
        check_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule